// File: doc/BRIEF.md
# Disk Controller Command Unit

This block sits behind a host register port of a disk drive controller. The host writes a 32-bit command word, and the unit decodes the operation from the upper halfword. It then updates a data register, a current-track register and three status flags. Seek commands copy the data register into the current-track register with two tag bits forced high. They also set or clear a mode flag, which a separate transfer engine uses to choose between writing and reading. Clock commands pack two calendar fields, already in packed BCD, into the top two bytes of the data register.

A hard-reset port accepts only one key value. The key raises the reset-state flag. A swap timer models media insertion. While the disk-present flag is low and a disk is physically inserted, periodic ticks are counted. After a set number of ticks the unit reports the disk as present and changed.

Top module: `dsk_cmd_unit`

## Requirements
- R1: After reset, the data, track and status registers read zero and `wr_mode` is low.
- R2: The operation is selected only by command bits 31:16. Bits 15:0 do not change the outcome. A word whose upper halfword matches no listed opcode (for example 0x1001) is treated as unknown.
- R3: Opcode 0x0001 loads track with data OR 0x60000000 and clears `wr_mode`. Opcode 0x0002 loads track the same way and sets `wr_mode`.
- R4: Opcode 0x0008 clears only the changed flag. Status bit positions are: bit 0 changed, bit 1 reset-state, bit 2 present, bits 31:3 zero.
- R5: Opcode 0x0009 clears the reset-state and changed flags and restarts the swap count from zero. If `disk_in` is high, it also sets present.
- R6: Opcodes 0x0012, 0x0013 and 0x0014 load data with {year,month}, {day,hour} and {minute,second} in bits 31:24 and 23:16, with bits 15:0 zero.
- R7: Opcode 0x001B loads data with zero.
- R8: Writing exactly 0xAAAA0000 to the hard-reset address sets reset-state, restarts the swap count and, if `disk_in` is high, sets present. Any other value written there has no effect.
- R9: While present is low and `disk_in` is high, every `tick` is counted. The SWAP_TICKS-th counted tick (50 by default) sets present and changed. Ticks have no effect while present is high or `disk_in` is low.
- R10: An unknown opcode leaves the data, track, status and `wr_mode` unchanged.
- R11: The address map is: 0 command (write-only, reads 0), 1 data (read/write), 2 status (read-only), 3 track (read-only), 4 hard-reset (write-only, reads 0). Reads are combinational in the cycle `rd_en` is high, and give 0 when `rd_en` is low. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 32 | Read data |
| rtc_year | input | 8 | Year, packed BCD |
| rtc_month | input | 8 | Month, packed BCD |
| rtc_day | input | 8 | Day, packed BCD |
| rtc_hour | input | 8 | Hour, packed BCD |
| rtc_min | input | 8 | Minute, packed BCD |
| rtc_sec | input | 8 | Second, packed BCD |
| disk_in | input | 1 | Media physically inserted |
| tick | input | 1 | Periodic swap-timer tick |
| wr_mode | output | 1 | High when the last seek was for writing |

## Verification
The hardest situation to reach is a swap count that was restarted partway through. Present never clears once it is set, so the only way back to an empty state is a full reset. After that reset the stimulus inserts a disk and delivers 30 ticks. It then removes the disk, issues opcode 0x0009 and re-inserts the disk. From there exactly 49 further ticks must leave present low, and the 50th must raise it. This distinguishes a real restart of the count from a count that merely paused.

// File: rtl/dsk_cmd_pkg.sv
package dsk_cmd_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SEEK_RD,
        OP_SEEK_WR,
        OP_CLR_CHG,
        OP_CLR_RST,
        OP_RTC_YM,
        OP_RTC_DH,
        OP_RTC_MS,
        OP_INQ
    } op_e;

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] track;
        logic        chg;
        logic        rst_st;
        logic        pres;
        logic        wmode;
    } regs_t;

    localparam int A_CMD   = 0;
    localparam int A_DATA  = 1;
    localparam int A_STAT  = 2;
    localparam int A_TRACK = 3;
    localparam int A_HRST  = 4;

    localparam logic [31:0] HRST_KEY  = 32'hAAAA_0000;
    localparam logic [31:0] TRACK_TAG = 32'h6000_0000;

endpackage

// File: rtl/dsk_cmd_decode.sv
module dsk_cmd_decode
    import dsk_cmd_pkg::*;
(
    input  logic [15:0] opcode,
    output op_e         op
);

    always_comb begin
        unique case (opcode)
            16'h0001: op = OP_SEEK_RD;
            16'h0002: op = OP_SEEK_WR;
            16'h0008: op = OP_CLR_CHG;
            16'h0009: op = OP_CLR_RST;
            16'h0012: op = OP_RTC_YM;
            16'h0013: op = OP_RTC_DH;
            16'h0014: op = OP_RTC_MS;
            16'h001B: op = OP_INQ;
            default:  op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/dsk_swap_timer.sv
module dsk_swap_timer #(
    parameter int SWAP_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic tick,
    input  logic clear,
    output logic done
);

    localparam int CW = $clog2(SWAP_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SWAP_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (armed && tick) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                done  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_SWAP_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(SWAP_TICKS)); // R9

    AST_SWAP_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(armed && tick)) |=> $stable(cnt_q)); // R9

    AST_SWAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/dsk_cmd_unit.sv
module dsk_cmd_unit
    import dsk_cmd_pkg::*;
#(
    parameter int SWAP_TICKS = 50,
    parameter int AW         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    input  logic [7:0]    rtc_year,
    input  logic [7:0]    rtc_month,
    input  logic [7:0]    rtc_day,
    input  logic [7:0]    rtc_hour,
    input  logic [7:0]    rtc_min,
    input  logic [7:0]    rtc_sec,
    input  logic          disk_in,
    input  logic          tick,
    output logic          wr_mode
);

    regs_t r_d, r_q;
    op_e   op;
    logic  cmd_wr, hrst_hit, swap_clr, swap_done, swap_armed;

    dsk_cmd_decode u_dec (
        .opcode (wr_data[31:16]),
        .op     (op)
    );

    assign swap_armed = !r_q.pres && disk_in;

    dsk_swap_timer #(.SWAP_TICKS(SWAP_TICKS)) u_swap (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (swap_armed),
        .tick  (tick),
        .clear (swap_clr),
        .done  (swap_done)
    );

    assign cmd_wr   = wr_en && (wr_addr == AW'(A_CMD));
    assign hrst_hit = wr_en && (wr_addr == AW'(A_HRST)) && (wr_data == HRST_KEY);
    assign swap_clr = hrst_hit || (cmd_wr && op == OP_CLR_RST);

    always_comb begin
        r_d = r_q;
        if (swap_done) begin
            r_d.pres = 1'b1;
            r_d.chg  = 1'b1;
        end
        if (cmd_wr) begin
            unique case (op)
                OP_SEEK_RD: begin
                    r_d.track = r_q.data | TRACK_TAG;
                    r_d.wmode = 1'b0;
                end
                OP_SEEK_WR: begin
                    r_d.track = r_q.data | TRACK_TAG;
                    r_d.wmode = 1'b1;
                end
                OP_CLR_CHG: r_d.chg = 1'b0;
                OP_CLR_RST: begin
                    r_d.rst_st = 1'b0;
                    r_d.chg    = 1'b0;
                    if (disk_in) r_d.pres = 1'b1;
                end
                OP_RTC_YM: r_d.data = {rtc_year, rtc_month, 16'h0000};
                OP_RTC_DH: r_d.data = {rtc_day,  rtc_hour,  16'h0000};
                OP_RTC_MS: r_d.data = {rtc_min,  rtc_sec,   16'h0000};
                OP_INQ:    r_d.data = '0;
                default:   ;
            endcase
        end
        if (wr_en && wr_addr == AW'(A_DATA)) r_d.data = wr_data;
        if (hrst_hit) begin
            r_d.rst_st = 1'b1;
            if (disk_in) r_d.pres = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == AW'(A_DATA))       rd_data = r_q.data;
            else if (rd_addr == AW'(A_STAT))  rd_data = {29'd0, r_q.pres, r_q.rst_st, r_q.chg};
            else if (rd_addr == AW'(A_TRACK)) rd_data = r_q.track;
        end
    end

    assign wr_mode = r_q.wmode;

    AST_PRES_NEEDS_DISK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pres) |-> $past(disk_in)); // R9

    AST_CHG_WITH_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.chg) |-> r_q.pres); // R9

    AST_TRACK_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.track != '0) |-> (r_q.track[30:29] == 2'b11)); // R3

    AST_UNKNOWN_OP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && op == OP_NONE) |=> ($stable(r_q.data) && $stable(r_q.track) && $stable(r_q.wmode))); // R10

    AST_RTC_YEAR_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data[31:16] == 16'h0012) |=> (r_q.data == {$past(rtc_year), $past(rtc_month), 16'h0000})); // R6

endmodule

// File: tb/dsk_cmd_unit_tb.sv
module dsk_cmd_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_data;
        logic [31:0] exp_track;
        logic [2:0]  exp_stat;
        logic        exp_mode;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{4'd11, 3'd1, 32'h0000_1234, 32'h0000_1234, 32'h0000_0000, 3'b000, 1'b0}, // R11 data write
        '{4'd3,  3'd0, 32'h0001_0000, 32'h0000_1234, 32'h6000_1234, 3'b000, 1'b0}, // R3 seek read
        '{4'd11, 3'd1, 32'h0ABC_0000, 32'h0ABC_0000, 32'h6000_1234, 3'b000, 1'b0}, // R11
        '{4'd2,  3'd0, 32'h0002_FFFF, 32'h0ABC_0000, 32'h6ABC_0000, 3'b000, 1'b1}, // R2 R3 seek write
        '{4'd6,  3'd0, 32'h0012_0000, 32'h2407_0000, 32'h6ABC_0000, 3'b000, 1'b1}, // R6
        '{4'd6,  3'd0, 32'h0013_5555, 32'h1523_0000, 32'h6ABC_0000, 3'b000, 1'b1}, // R6
        '{4'd6,  3'd0, 32'h0014_0000, 32'h5908_0000, 32'h6ABC_0000, 3'b000, 1'b1}, // R6
        '{4'd10, 3'd0, 32'h0005_0000, 32'h5908_0000, 32'h6ABC_0000, 3'b000, 1'b1}, // R10
        '{4'd7,  3'd0, 32'h001B_0000, 32'h0000_0000, 32'h6ABC_0000, 3'b000, 1'b1}, // R7
        '{4'd3,  3'd0, 32'h0001_0000, 32'h0000_0000, 32'h6000_0000, 3'b000, 1'b0}, // R3
        '{4'd2,  3'd0, 32'h1001_0000, 32'h0000_0000, 32'h6000_0000, 3'b000, 1'b0}, // R2 upper bits
        '{4'd8,  3'd4, 32'hAAAA_0001, 32'h0000_0000, 32'h6000_0000, 3'b000, 1'b0}, // R8 bad key
        '{4'd8,  3'd4, 32'hAAAA_0000, 32'h0000_0000, 32'h6000_0000, 3'b010, 1'b0}, // R8 key
        '{4'd4,  3'd0, 32'h0008_0000, 32'h0000_0000, 32'h6000_0000, 3'b010, 1'b0}, // R4
        '{4'd5,  3'd0, 32'h0009_0000, 32'h0000_0000, 32'h6000_0000, 3'b000, 1'b0}  // R5 no disk
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, disk_in = 1'b0, tick = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic wr_mode;
    int checks = 0, failures = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsk_cmd_unit #(.SWAP_TICKS(50), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rtc_year(8'h24), .rtc_month(8'h07), .rtc_day(8'h15), .rtc_hour(8'h23),
        .rtc_min(8'h59), .rtc_sec(8'h08), .disk_in(disk_in), .tick(tick), .wr_mode(wr_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = a; #1; v = rd_data; rd_en = 1'b0; #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd1, v); check("R1 data", v, 32'h0);
        rd(3'd2, v); check("R1 status", v, 32'h0);
        rd(3'd3, v); check("R1 track", v, 32'h0);
        check("R1 wr_mode", {31'd0, wr_mode}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            wr(TBL[i].addr, TBL[i].wdata);
            tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
            rd(3'd1, v); check(tag, v, TBL[i].exp_data);
            rd(3'd3, v); check(tag, v, TBL[i].exp_track);
            rd(3'd2, v); check(tag, v, {29'd0, TBL[i].exp_stat});
            check(tag, {31'd0, wr_mode}, {31'd0, TBL[i].exp_mode});
        end

        // R11 read timing, read-only status, strobe gating
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'hCAFE_0000;
        rd(3'd1, v); check("R11 before edge", v, 32'h0);
        @(negedge clk); wr_en = 1'b0;
        rd(3'd1, v); check("R11 after edge", v, 32'hCAFE_0000);
        #1; check("R11 no strobe", rd_data, 32'h0);
        wr(3'd2, 32'h7); rd(3'd2, v); check("R11 status ro", v, 32'h0);
        rd(3'd0, v); check("R11 cmd reads 0", v, 32'h0);

        // R9 ticks without disk ignored, then 50 ticks with disk
        ticks(60); rd(3'd2, v); check("R9 no disk", v, 32'h0);
        disk_in = 1'b1;
        ticks(49); rd(3'd2, v); check("R9 49 ticks", v, 32'h0);
        ticks(1);  rd(3'd2, v); check("R9 50th tick", v, 32'h5);
        ticks(60); rd(3'd2, v); check("R9 present holds", v, 32'h5);
        wr(3'd0, 32'h0008_0000); rd(3'd2, v); check("R4 clear chg", v, 32'h4);

        // R5 restart of swap count
        do_reset(); disk_in = 1'b1;
        ticks(30);
        disk_in = 1'b0;
        wr(3'd0, 32'h0009_0000); rd(3'd2, v); check("R5 no disk", v, 32'h0);
        disk_in = 1'b1;
        ticks(49); rd(3'd2, v); check("R5 count restarted", v, 32'h0);
        ticks(1);  rd(3'd2, v); check("R5 swap after restart", v, 32'h5);

        // R5 with disk sets present at once
        do_reset();
        wr(3'd0, 32'h0009_1234); rd(3'd2, v); check("R5 disk present", v, 32'h4);

        // R8 with disk inserted
        do_reset();
        wr(3'd4, 32'hAAAA_0000); rd(3'd2, v); check("R8 disk present", v, 32'h6);
        rd(3'd1, v); check("R1 data after reset", v, 32'h0);

        finish_run();
    end

endmodule